// File: doc/BRIEF.md
# DMA Global Hold Gate

This block sits between the per-channel DMA request lines and the bus arbiter. A single software-written hold bit stops every channel at once, so the CPU can fetch from the data flash with no DMA transfer on the bus at the same moment. If a flash read overlaps a DMA transfer, the read can return wrong data.

Requests that arrive while the hold bit is set are latched per channel and are never dropped. When the bit clears, they are released one per cycle, lowest channel index first. The same pending latches and priority pick also serve normal running. The gate raises a read-safe status once the hold bit has been set for a settle window and the arbiter reports no transfer still in flight. A flash read strobe that arrives while read-safe is low sets a sticky violation flag. Flash program, verify and blank-check operations never come through this gate. Only the read strobe is watched.

The control state machine has three states:
- `ST_RUN`: hold is off.
- `ST_SETTLE`: hold is on and the settle window is being counted.
- `ST_HELD`: hold is on and the window has elapsed.

It has five transitions:
- RUN→SETTLE when the hold bit is seen set.
- SETTLE→SETTLE while counting.
- SETTLE→HELD when the count reaches `SETTLE` clocks.
- SETTLE→RUN when hold clears early.
- HELD→RUN when hold clears.

Top module: `dma_hold_gate`

## Requirements
- R1: After reset, `gnt_req` is 0, `hold_rb` is 0, `rd_safe` is 0 and `rd_viol` is 0.
- R2: While hold is off, `gnt_req` has at most one bit set. Each pulse on `chan_req[i]` produces one cycle of `gnt_req[i]`. Bit i corresponds to channel i. When several requests are pending, the lowest index is granted first, one grant per cycle. A grant appears in the cycle after the request edge.
- R3: From the cycle after a write of 1 to the hold bit, `gnt_req` is all zero for as long as the hold bit stays 1.
- R4: A request pulse that arrives while hold is set is latched. After hold is written to 0, each latched request is granted exactly once, in ascending channel order, starting in the cycle after the clearing edge.
- R5: `rd_safe` rises only after the hold bit has been 1 at `SETTLE` (default 2) consecutive clock edges. It is low in the first `SETTLE` cycles after the write edge.
- R6: `rd_safe` is low in any cycle where `dma_busy` is 1.
- R7: A cycle with `flash_rd` = 1 while `rd_safe` = 0 sets `rd_viol` at the next edge. `rd_viol` then stays 1 until reset.
- R8: A `flash_rd` strobe while `rd_safe` = 1 leaves `rd_viol` at 0.
- R9: `hold_rb` returns the hold bit last written through `hold_we`/`hold_wd`, from the cycle after the write.
- R10: Writing the hold bit to 0 drops `rd_safe` in the cycle after the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| chan_req | input | NCH | Per-channel request pulses from the DMA channels |
| hold_we | input | 1 | Write strobe for the hold bit |
| hold_wd | input | 1 | Value written to the hold bit |
| flash_rd | input | 1 | CPU data-flash read strobe |
| dma_busy | input | 1 | A granted transfer is still in flight |
| gnt_req | output | NCH | Gated requests to the bus arbiter |
| hold_rb | output | 1 | Readback of the hold bit |
| rd_safe | output | 1 | A flash read may proceed |
| rd_viol | output | 1 | Sticky flag: a flash read happened while unsafe |

## Verification
Inputs are driven on the falling edge. A grant is due one rising edge after its request pulse. A grant for a request latched under hold is due one edge after the clearing write. The hold readback and the gating of `gnt_req` take effect one edge after the write. `rd_safe` is low at the first and second falling edges after the write edge and high from the third. The violation flag follows one edge after the offending strobe. The bench samples each result at the falling edge that ends the cycle in which it is due, two time units after the edge. A scoreboard queue receives the expected channel order when each request is driven. The monitor flags any grant that arrives when nothing is expected or out of order.

// File: rtl/dma_hold_pkg.sv
package dma_hold_pkg;
    typedef enum logic [1:0] {
        ST_RUN    = 2'd0,
        ST_SETTLE = 2'd1,
        ST_HELD   = 2'd2
    } hold_state_t;
endpackage

// File: rtl/dma_req_pend.sv
module dma_req_pend #(
    parameter int NCH = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] req,
    input  logic           hold,
    output logic [NCH-1:0] gnt
);
    logic [NCH-1:0] pend_q;
    logic [NCH-1:0] pick;

    // lowest set index wins
    genvar gi;
    generate
        for (gi = 0; gi < NCH; gi++) begin : g_pick
            if (gi == 0) begin : g_first
                assign pick[gi] = pend_q[gi];
            end else begin : g_rest
                assign pick[gi] = pend_q[gi] & ~(|pend_q[gi-1:0]);
            end
        end
    endgenerate

    assign gnt = hold ? '0 : pick;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= (pend_q & ~gnt) | req;
    end
endmodule

// File: rtl/dma_settle_fsm.sv
module dma_settle_fsm
    import dma_hold_pkg::*;
#(
    parameter int SETTLE = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hold,
    input  logic busy,
    input  logic flash_rd,
    output logic rd_safe,
    output logic rd_viol
);
    localparam int CW = $clog2(SETTLE + 1);

    hold_state_t st_q, st_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic          viol_q;

    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        unique case (st_q)
            ST_RUN: begin
                if (hold) begin
                    st_d  = ST_SETTLE;
                    cnt_d = CW'(1);
                end
            end
            ST_SETTLE: begin
                if (!hold) begin
                    st_d  = ST_RUN;
                    cnt_d = '0;
                end else if (cnt_q + CW'(1) >= CW'(SETTLE)) begin
                    st_d  = ST_HELD;
                end else begin
                    cnt_d = cnt_q + CW'(1);
                end
            end
            ST_HELD: begin
                if (!hold) begin
                    st_d  = ST_RUN;
                    cnt_d = '0;
                end
            end
            default: begin
                st_d  = ST_RUN;
                cnt_d = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= ST_RUN;
            cnt_q  <= '0;
            viol_q <= 1'b0;
        end else begin
            st_q   <= st_d;
            cnt_q  <= cnt_d;
            viol_q <= viol_q | (flash_rd & ~rd_safe);
        end
    end

    always_comb begin
        rd_safe = (st_q == ST_HELD) && hold && !busy;
        rd_viol = viol_q;
    end
endmodule

// File: rtl/dma_hold_gate.sv
module dma_hold_gate #(
    parameter int NCH    = 4,
    parameter int SETTLE = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] chan_req,
    input  logic           hold_we,
    input  logic           hold_wd,
    input  logic           flash_rd,
    input  logic           dma_busy,
    output logic [NCH-1:0] gnt_req,
    output logic           hold_rb,
    output logic           rd_safe,
    output logic           rd_viol
);
    logic hold_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       hold_q <= 1'b0;
        else if (hold_we) hold_q <= hold_wd;
    end

    assign hold_rb = hold_q;

    dma_req_pend #(.NCH(NCH)) u_pend (
        .clk  (clk),
        .rst_n(rst_n),
        .req  (chan_req),
        .hold (hold_q),
        .gnt  (gnt_req)
    );

    dma_settle_fsm #(.SETTLE(SETTLE)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .hold    (hold_q),
        .busy    (dma_busy),
        .flash_rd(flash_rd),
        .rd_safe (rd_safe),
        .rd_viol (rd_viol)
    );
endmodule

// File: rtl/dma_hold_gate_chk.sv
module dma_hold_gate_chk #(
    parameter int NCH = 4
) (
    input logic           clk,
    input logic           rst_n,
    input logic           hold_we,
    input logic           hold_wd,
    input logic           flash_rd,
    input logic           dma_busy,
    input logic [NCH-1:0] gnt_req,
    input logic           hold_rb,
    input logic           rd_safe,
    input logic           rd_viol
);
    // R2
    gnt_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt_req));

    // R3
    hold_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hold_rb |-> (gnt_req == '0));

    // R5
    safe_needs_settle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_safe |-> (hold_rb && $past(hold_rb)));

    // R6
    safe_not_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_safe |-> !dma_busy);

    // R7
    viol_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flash_rd && !rd_safe) |=> rd_viol);

    // R7
    viol_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_viol |=> rd_viol);

    // R9
    readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hold_we |=> (hold_rb == $past(hold_wd)));
endmodule

bind dma_hold_gate dma_hold_gate_chk #(.NCH(NCH)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .hold_we (hold_we),
    .hold_wd (hold_wd),
    .flash_rd(flash_rd),
    .dma_busy(dma_busy),
    .gnt_req (gnt_req),
    .hold_rb (hold_rb),
    .rd_safe (rd_safe),
    .rd_viol (rd_viol)
);

// File: tb/dma_hold_gate_test.sv
module dma_hold_gate_test;
    localparam int NCH = 4;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [NCH-1:0] chan_req = '0;
    logic           hold_we = 1'b0;
    logic           hold_wd = 1'b0;
    logic           flash_rd = 1'b0;
    logic           dma_busy = 1'b0;
    logic [NCH-1:0] gnt_req;
    logic           hold_rb, rd_safe, rd_viol;

    int checks = 0;
    int errors = 0;
    int exp_q[$];

    always #10 clk = ~clk;

    dma_hold_gate #(.NCH(NCH), .SETTLE(2)) uut (
        .clk(clk), .rst_n(rst_n), .chan_req(chan_req), .hold_we(hold_we),
        .hold_wd(hold_wd), .flash_rd(flash_rd), .dma_busy(dma_busy),
        .gnt_req(gnt_req), .hold_rb(hold_rb), .rd_safe(rd_safe), .rd_viol(rd_viol)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // driver: pulse requests and push expected grant order
    task automatic pulse_req(input logic [NCH-1:0] m, input bit expect_now);
        if (expect_now)
            for (int i = 0; i < NCH; i++) if (m[i]) exp_q.push_back(i);
        @(negedge clk) chan_req = m;
        @(negedge clk) chan_req = '0;
    endtask

    task automatic write_hold(input logic v);
        @(negedge clk) begin hold_we = 1'b1; hold_wd = v; end
        @(negedge clk) hold_we = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // monitor: pops the scoreboard on every grant (R2, R3, R4)
    always @(negedge clk) begin
        #2;
        if (rst_n && gnt_req != '0) begin
            int got;
            got = -1;
            for (int i = NCH - 1; i >= 0; i--) if (gnt_req[i]) got = i;
            if (exp_q.size() == 0) begin
                chk("R3 unexpected grant", got, -1);
            end else begin
                chk("R2/R4 grant order", got, exp_q.pop_front());
            end
        end
    end

    initial begin
        #(20 * 50000);
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        idle(2);
        #2;
        // R1
        chk("R1 gnt", gnt_req, 0);
        chk("R1 hold_rb", hold_rb, 0);
        chk("R1 rd_safe", rd_safe, 0);
        chk("R1 rd_viol", rd_viol, 0);
        rst_n = 1'b1;
        idle(1);

        // R2 single and multiple requests while running
        pulse_req(4'b0100, 1'b1);
        idle(2);
        pulse_req(4'b1011, 1'b1);
        idle(4);
        chk("R2 queue drained", exp_q.size(), 0);

        // R9, R3, R5
        write_hold(1'b1);
        #1;
        chk("R9 readback 1", hold_rb, 1);
        chk("R5 safe low cycle1", rd_safe, 0);
        @(negedge clk); #1;
        chk("R5 safe low cycle2", rd_safe, 0);
        @(negedge clk); #1;
        chk("R5 safe high", rd_safe, 1);

        // R8 safe read
        @(negedge clk) flash_rd = 1'b1;
        @(negedge clk) flash_rd = 1'b0;
        #1;
        chk("R8 no viol", rd_viol, 0);

        // R6
        @(negedge clk) dma_busy = 1'b1;
        #1;
        chk("R6 busy blocks safe", rd_safe, 0);
        @(negedge clk) dma_busy = 1'b0;
        #1;
        chk("R6 safe after busy", rd_safe, 1);

        // R4 requests during hold; monitor flags any grant (R3)
        pulse_req(4'b0101, 1'b0);
        pulse_req(4'b1000, 1'b0);
        idle(3);
        chk("R3 held gnt", gnt_req, 0);
        exp_q.push_back(0);
        exp_q.push_back(2);
        exp_q.push_back(3);
        write_hold(1'b0);
        #1;
        chk("R9 readback 0", hold_rb, 0);
        chk("R10 safe drops", rd_safe, 0);
        idle(5);
        chk("R4 all released", exp_q.size(), 0);

        // R7 violation and stickiness
        @(negedge clk) flash_rd = 1'b1;
        @(negedge clk) flash_rd = 1'b0;
        #1;
        chk("R7 viol set", rd_viol, 1);
        idle(3);
        #1;
        chk("R7 viol sticky", rd_viol, 1);
        write_hold(1'b1);
        idle(3);
        #1;
        chk("R7 viol sticky under hold", rd_viol, 1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule